// File: doc/BRIEF.md
# Performance Monitor Counter Unit

The block is a compact performance monitor: four 32-bit event counters, a global control word and an event-select word, all reached through a plain register read/write port. Every clock, each counter that is not frozen looks up its own 8-bit event code and advances by one cycle or by the number of instructions retired in that cycle. One counter has an extra event that counts retired instructions only while a run-latch input is high.

Any counter that moves from non-negative to negative (bit 31 going from 0 to 1) while its condition enable is set raises a sticky alert. If the event-branch enable is also set, an event-branch request is raised as well. Both stay high until software writes 0 to the alert bit. The block comes out of reset with the global freeze set, so no counter runs until software clears it.

Top module: `pmon_unit`

## Requirements
- R1: After reset the control word reads 0x80000000, the event word and all four counters read 0, and alertOut and ebbReq are low.
- R2: Register addresses: 0 is control, 1 is event select, 2 to 5 are counters 1 to 4. In the control word, bit 31 is global freeze, bits 3:0 freeze counters 1 to 4, bit 8 is the condition enable for counter 1, bit 9 is the condition enable shared by counters 2 to 4, bit 12 is the event-branch enable and bit 16 is the alert flag. All other bits read 0. Counter n takes its event code from byte n-1 of the event word (bits 8(n-1)+7 down to 8(n-1)).
- R3: Code 0x1E on any counter, and code 0xF0 on counter 1 only, adds exactly 1 per clock.
- R4: Code 0x02 on any counter, and code 0xFE on counter 1 only, adds retireCnt (0 to 2) in the same clock.
- R5: A counter does not change while global freeze or its own freeze bit is set.
- R6: Code 0xFA on counter 4 only adds retireCnt, and only in clocks where runLatch is high.
- R7: Any other code, including 0xF0, 0xFE and 0xFA on counters where they do not apply, leaves the counter unchanged.
- R8: A write to a counter loads the written value in that clock and takes priority over counting.
- R9: A counter whose bit 31 goes from 0 to 1 by counting, with its condition enable set, sets the alert flag. The flag is sticky: writing 0 to bit 16 clears it, and writing 1 to bit 16 leaves it unchanged. If a hardware set and a clearing write fall in the same clock, the set wins. alertOut mirrors the flag.
- R10: An alert raised while the event-branch enable is set also sets ebbReq, which stays high until the alert flag is cleared. An alert raised with the enable clear leaves ebbReq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| retireCnt | input | 2 | Instructions retired this clock (0 to 2) |
| runLatch | input | 1 | Run-latch state gating event 0xFA on counter 4 |
| alertOut | output | 1 | Sticky performance monitor alert |
| ebbReq | output | 1 | Event-branch request |

## Verification
All 256 event codes are swept on counters 1, 2 and 4. Each run uses a short burst with a mixed retire count and toggled run latch, so that cycle events (+3), instruction events (+5), latch-gated events (+4) and idle codes (+0) produce four distinct end values. This also separates the counter-1-only and counter-4-only codes from the shared codes. Separate runs cover the two freeze levels and a write that collides with counting. Counters are preset just below the sign boundary to exercise both the per-counter and the shared condition enables, the event-branch enable on and off, and the behaviour of the alert bit when written with 1 and with 0.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int NUM_CNT   = 4;
  localparam int CNT_W     = 32;
  localparam int RET_W     = 2;
  localparam int ADDR_W    = 3;
  localparam int CODE_W    = 8;
  localparam int CNT_BASE  = 2;

  localparam int GFRZ_BIT  = 31;
  localparam int CE1_BIT   = 8;
  localparam int CEN_BIT   = 9;
  localparam int EBE_BIT   = 12;
  localparam int ALERT_BIT = 16;

  localparam logic [CODE_W-1:0] EV_CYC      = 8'h1E;
  localparam logic [CODE_W-1:0] EV_INS      = 8'h02;
  localparam logic [CODE_W-1:0] EV_CYC_C1   = 8'hF0;
  localparam logic [CODE_W-1:0] EV_INS_C1   = 8'hFE;
  localparam logic [CODE_W-1:0] EV_RUN_C4   = 8'hFA;
  localparam int RUN_CNT_IDX = 3;

  typedef struct packed {
    logic [NUM_CNT-1:0]            cntWr;
    logic [NUM_CNT-1:0][RET_W-1:0] incAmt;
  } cntStrobe_t;
endpackage

// File: rtl/pmon_evt_decode.sv
module pmon_evt_decode
  import pmon_pkg::*;
#(
  parameter int CNT_IDX = 0
) (
  input  logic [CODE_W-1:0] evtCode,
  input  logic              active,
  input  logic [RET_W-1:0]  retireCnt,
  input  logic              runLatch,
  output logic [RET_W-1:0]  incAmt
);
  logic isCyc;
  logic isIns;
  logic isRun;

  generate
    if (CNT_IDX == 0) begin : g_first
      assign isCyc = (evtCode == EV_CYC) || (evtCode == EV_CYC_C1);
      assign isIns = (evtCode == EV_INS) || (evtCode == EV_INS_C1);
    end else begin : g_other
      assign isCyc = (evtCode == EV_CYC);
      assign isIns = (evtCode == EV_INS);
    end
    if (CNT_IDX == RUN_CNT_IDX) begin : g_run
      assign isRun = (evtCode == EV_RUN_C4);
    end else begin : g_norun
      assign isRun = 1'b0;
    end
  endgenerate

  always_comb begin
    incAmt = '0;
    if (active) begin
      if (isCyc)                incAmt = RET_W'(1);
      else if (isIns)           incAmt = retireCnt;
      else if (isRun && runLatch) incAmt = retireCnt;
    end
  end
endmodule

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWrEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [CNT_W-1:0]                regWrData,
  input  logic [RET_W-1:0]                retireCnt,
  input  logic                            runLatch,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cntVals,
  input  logic [NUM_CNT-1:0]              crossEvt,
  output cntStrobe_t                      strobe,
  output logic [CNT_W-1:0]                regRdData,
  output logic [CNT_W-1:0]                ctlWord,
  output logic                            alertOut,
  output logic                            ebbReq
);
  localparam int EVT_W = NUM_CNT * CODE_W;

  logic                           gFreeze;
  logic [NUM_CNT-1:0]             cntFreeze;
  logic                           ceFirst;
  logic                           ceRest;
  logic                           ebEnable;
  logic                           alertFlag;
  logic                           reqFlag;
  logic [NUM_CNT-1:0][CODE_W-1:0] evtSel;

  logic ctlWr;
  logic evtWr;
  logic alertSet;
  logic alertNext;
  logic reqNext;

  assign ctlWr = regWrEn && (regAddr == ADDR_W'(0));
  assign evtWr = regWrEn && (regAddr == ADDR_W'(1));

  genvar k;
  generate
    for (k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic active;
      assign active = !gFreeze && !cntFreeze[k];
      assign strobe.cntWr[k] = regWrEn && (regAddr == ADDR_W'(k + CNT_BASE));
      pmon_evt_decode #(.CNT_IDX(k)) i_dec (
        .evtCode  (evtSel[k]),
        .active   (active),
        .retireCnt(retireCnt),
        .runLatch (runLatch),
        .incAmt   (strobe.incAmt[k])
      );
    end
  endgenerate

  assign alertSet  = (crossEvt[0] && ceFirst) ||
                     ((|crossEvt[NUM_CNT-1:1]) && ceRest);
  assign alertNext = alertSet ||
                     (ctlWr ? (regWrData[ALERT_BIT] && alertFlag) : alertFlag);
  assign reqNext   = (alertSet && ebEnable) || (reqFlag && alertNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gFreeze   <= 1'b1;
      cntFreeze <= '0;
      ceFirst   <= 1'b0;
      ceRest    <= 1'b0;
      ebEnable  <= 1'b0;
      alertFlag <= 1'b0;
      reqFlag   <= 1'b0;
      evtSel    <= '0;
    end else begin
      alertFlag <= alertNext;
      reqFlag   <= reqNext;
      if (ctlWr) begin
        gFreeze   <= regWrData[GFRZ_BIT];
        cntFreeze <= regWrData[NUM_CNT-1:0];
        ceFirst   <= regWrData[CE1_BIT];
        ceRest    <= regWrData[CEN_BIT];
        ebEnable  <= regWrData[EBE_BIT];
      end
      if (evtWr) evtSel <= regWrData[EVT_W-1:0];
    end
  end

  always_comb begin
    ctlWord              = '0;
    ctlWord[GFRZ_BIT]    = gFreeze;
    ctlWord[NUM_CNT-1:0] = cntFreeze;
    ctlWord[CE1_BIT]     = ceFirst;
    ctlWord[CEN_BIT]     = ceRest;
    ctlWord[EBE_BIT]     = ebEnable;
    ctlWord[ALERT_BIT]   = alertFlag;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(0))      regRdData = ctlWord;
    else if (regAddr == ADDR_W'(1)) regRdData = CNT_W'(evtSel);
    else begin
      for (int i = 0; i < NUM_CNT; i++)
        if (regAddr == ADDR_W'(i + CNT_BASE)) regRdData = cntVals[i];
    end
  end

  assign alertOut = alertFlag;
  assign ebbReq   = reqFlag;
endmodule

// File: rtl/pmon_datapath.sv
module pmon_datapath
  import pmon_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  cntStrobe_t                    strobe,
  input  logic [CNT_W-1:0]              regWrData,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVals,
  output logic [NUM_CNT-1:0]            crossEvt
);
  genvar k;
  generate
    for (k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic [CNT_W-1:0] cntQ;
      logic [CNT_W-1:0] sum;
      assign sum = cntQ + CNT_W'(strobe.incAmt[k]);
      assign crossEvt[k] = !strobe.cntWr[k] && (strobe.incAmt[k] != '0) &&
                           !cntQ[CNT_W-1] && sum[CNT_W-1];
      always_ff @(posedge clk) begin
        if (!rstN)                cntQ <= '0;
        else if (strobe.cntWr[k]) cntQ <= regWrData;
        else                      cntQ <= sum;
      end
      assign cntVals[k] = cntQ;
    end
  endgenerate
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
  import pmon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic [RET_W-1:0]  retireCnt,
  input  logic              runLatch,
  output logic              alertOut,
  output logic              ebbReq
);
  cntStrobe_t                    strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVals;
  logic [NUM_CNT-1:0]            crossEvt;
  logic [CNT_W-1:0]              globalCtl;

  pmon_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .retireCnt(retireCnt),
    .runLatch (runLatch),
    .cntVals  (cntVals),
    .crossEvt (crossEvt),
    .strobe   (strobe),
    .regRdData(regRdData),
    .ctlWord  (globalCtl),
    .alertOut (alertOut),
    .ebbReq   (ebbReq)
  );

  pmon_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWrData(regWrData),
    .cntVals  (cntVals),
    .crossEvt (crossEvt)
  );
endmodule

// File: rtl/pmon_checker.sv
module pmon_checker
  import pmon_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWrEn,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [CNT_W-1:0]              regWrData,
  input logic                          alertOut,
  input logic                          ebbReq,
  input logic [CNT_W-1:0]              globalCtl,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVals
);
  p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (globalCtl[GFRZ_BIT] && !regWrEn) |=> $stable(cntVals));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(CNT_BASE)) |=> (cntVals[0] == $past(regWrData)));

  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((cntVals[1] - $past(cntVals[1])) <= CNT_W'(2)));

  p_alert_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (alertOut && !(regWrEn && regAddr == ADDR_W'(0))) |=> alertOut);

  p_req_needs_alert_r10: assert property (@(posedge clk) disable iff (!rstN)
    ebbReq |-> alertOut);

  p_alert_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    alertOut == globalCtl[ALERT_BIT]);
endmodule

bind pmon_unit pmon_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .alertOut (alertOut),
  .ebbReq   (ebbReq),
  .globalCtl(globalCtl),
  .cntVals  (cntVals)
);

// File: tb/test_pmon_unit.sv
`timescale 1ns/100ps
module test_pmon_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  retireCnt = '0;
  logic        runLatch = 1'b0;
  logic        alertOut;
  logic        ebbReq;

  int nTests = 0;
  int nFail  = 0;

  // model state
  logic [31:0] mCnt [4];
  logic [7:0]  mEvt [4];
  logic        mGf, mCe1, mCeN, mEbe, mAl, mRq;
  logic [3:0]  mFz;

  always #2 clk = ~clk;

  pmon_unit i_pmon_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .retireCnt(retireCnt),
    .runLatch(runLatch), .alertOut(alertOut), .ebbReq(ebbReq)
  );

  // 0 idle, 1 cycle, 2 instruction, 3 latch-gated instruction
  function automatic int kindOf(int k, logic [7:0] c);
    if (c == 8'h1E || (k == 0 && c == 8'hF0)) return 1;
    if (c == 8'h02 || (k == 0 && c == 8'hFE)) return 2;
    if (k == 3 && c == 8'hFA) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] modelRead(logic [2:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 0) begin
      v[31] = mGf; v[3:0] = mFz; v[8] = mCe1; v[9] = mCeN; v[12] = mEbe; v[16] = mAl;
    end else if (a == 1) v = {mEvt[3], mEvt[2], mEvt[1], mEvt[0]};
    else if (a <= 5) v = mCnt[a-2];
    return v;
  endfunction

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic [1:0] r, input logic l);
    logic c1, cN, setA, newAl, newRq;
    logic [31:0] inc, nv;
    regWrEn = we; regAddr = a; regWrData = d; retireCnt = r; runLatch = l;
    @(posedge clk);
    c1 = 1'b0; cN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      inc = 0;
      if (!mGf && !mFz[k]) begin
        case (kindOf(k, mEvt[k]))
          1: inc = 1;
          2: inc = 32'(r);
          3: inc = l ? 32'(r) : 0;
          default: inc = 0;
        endcase
      end
      nv = mCnt[k] + inc;
      if (!(we && a == 3'(k + 2))) begin
        if (inc != 0 && !mCnt[k][31] && nv[31]) begin
          if (k == 0) c1 = 1'b1; else cN = 1'b1;
        end
        mCnt[k] = nv;
      end
    end
    setA  = (c1 && mCe1) || (cN && mCeN);
    newAl = setA || ((we && a == 0) ? (d[16] && mAl) : mAl);
    newRq = (setA && mEbe) || (mRq && newAl);
    mAl = newAl; mRq = newRq;
    if (we) begin
      if (a == 0) begin
        mGf = d[31]; mFz = d[3:0]; mCe1 = d[8]; mCeN = d[9]; mEbe = d[12];
      end else if (a == 1) begin
        for (int k = 0; k < 4; k++) mEvt[k] = d[8*k +: 8];
      end else if (a <= 5) mCnt[a-2] = d;
    end
    #0.5;
    regWrEn = 1'b0;
  endtask

  task automatic chkReg(input logic [2:0] a, input string tag);
    logic [31:0] e;
    regAddr = a;
    #0.1;
    e = modelRead(a);
    nTests++;
    if (regRdData !== e) begin
      nFail++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, regRdData, e);
    end
  endtask

  task automatic chkOut(input string tag);
    nTests++;
    if (alertOut !== mAl || ebbReq !== mRq) begin
      nFail++;
      $display("FAIL %s outputs: alert/req got %b%b expected %b%b",
               tag, alertOut, ebbReq, mAl, mRq);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'h0, 2'd1, 1'b0);
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mCnt[k] = '0; mEvt[k] = '0; end
    mGf = 1'b1; mFz = '0; mCe1 = 0; mCeN = 0; mEbe = 0; mAl = 0; mRq = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) chkReg(3'(a), "R1");
    chkOut("R1");

    // R5 global freeze: codes set but frozen
    step(1'b1, 3'd1, 32'h1E1E1E1E, 2'd2, 1'b1);
    idle(5);
    for (int a = 2; a < 6; a++) chkReg(3'(a), "R5");
    chkReg(3'd1, "R2");

    // R3 R4 R6 R7 sweep of all codes on counters 1, 2 and 4
    step(1'b1, 3'd0, 32'h0, 2'd0, 1'b0);
    for (int ki = 0; ki < 3; ki++) begin
      int k;
      k = (ki == 2) ? 3 : ki;
      for (int c = 0; c < 256; c++) begin
        string tag;
        case (kindOf(k, 8'(c)))
          1: tag = "R3"; 2: tag = "R4"; 3: tag = "R6"; default: tag = "R7";
        endcase
        step(1'b1, 3'd1, 32'(c) << (8 * k), 2'd0, 1'b0);
        step(1'b1, 3'(k + 2), 32'h0, 2'd0, 1'b0);
        step(1'b0, 3'd0, 32'h0, 2'd2, 1'b1);
        step(1'b0, 3'd0, 32'h0, 2'd1, 1'b0);
        step(1'b0, 3'd0, 32'h0, 2'd2, 1'b1);
        chkReg(3'(k + 2), tag);
      end
    end

    // R5 per-counter freeze on counter 2
    step(1'b1, 3'd1, 32'h1E1E1E1E, 2'd0, 1'b0);
    step(1'b1, 3'd0, 32'h00000002, 2'd0, 1'b0);
    step(1'b1, 3'd2, 32'h0, 2'd0, 1'b0);
    step(1'b1, 3'd3, 32'h55, 2'd0, 1'b0);
    idle(4);
    chkReg(3'd2, "R5");
    chkReg(3'd3, "R5");
    chkReg(3'd0, "R2");

    // R8 write collides with counting
    step(1'b1, 3'd2, 32'd100, 2'd2, 1'b0);
    chkReg(3'd2, "R8");
    idle(1);
    chkReg(3'd2, "R8");

    // R9 R10 alert on counter 1 with event-branch enable
    step(1'b1, 3'd0, 32'h00001100, 2'd0, 1'b0);
    step(1'b1, 3'd2, 32'h7FFFFFFE, 2'd0, 1'b0);
    idle(1);
    chkOut("R9");
    idle(1);
    chkReg(3'd2, "R9");
    chkOut("R10");
    chkReg(3'd0, "R9");
    idle(3);
    chkOut("R9");
    step(1'b1, 3'd0, 32'h00011100, 2'd0, 1'b0);
    chkOut("R9");
    step(1'b1, 3'd0, 32'h00001100, 2'd0, 1'b0);
    chkOut("R10");
    chkReg(3'd0, "R9");

    // R9 shared enable on counter 3 via instructions, R10 enable off
    step(1'b1, 3'd0, 32'h00000200, 2'd0, 1'b0);
    step(1'b1, 3'd1, 32'h00020000, 2'd0, 1'b0);
    step(1'b1, 3'd4, 32'h7FFFFFFF, 2'd0, 1'b0);
    step(1'b0, 3'd0, 32'h0, 2'd2, 1'b0);
    chkReg(3'd4, "R4");
    chkOut("R10");
    step(1'b1, 3'd0, 32'h00000200, 2'd0, 1'b0);
    chkOut("R9");

    // R9 counter 1 crossing with only the shared enable: no alert
    step(1'b1, 3'd1, 32'h000000F0, 2'd0, 1'b0);
    step(1'b1, 3'd2, 32'h7FFFFFFF, 2'd0, 1'b0);
    idle(2);
    chkReg(3'd2, "R3");
    chkOut("R9");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule